// File: doc/BRIEF.md
# Synchronous Bus Cycle Sequencer

This block is the master side of a bus that has separate address and data lines and a shared clock. It turns one read or write request from the user side into a fixed three-cycle bus transfer. Every bus event happens at a set point of a set cycle. The address appears at the start of the first cycle. An address-enable strobe follows at mid-cycle, once the address lines have settled. The read command, or the write data, comes at the start of the second cycle. For writes, the write command is raised at mid-cycle, after the data has settled. The transfer ends at the close of the third cycle.

A user raises `req_i` with `we_i`, `addr_i` and `wdata_i` while `ready_o` is high. The request is taken at that clock edge. `done_o` is high through the final cycle. For reads, `rdata_o` takes the value on `bus_din_i` at the edge that closes the transfer. Mid-cycle strobes come from falling-edge registers, so they lag the rising-edge address and data by half a clock period. The memory slave is expected to answer a read with data in the third cycle, and to latch write data by the end of that cycle.

Top module: `sbus_seq`

## Requirements
- R1: After reset, and whenever no transfer is running, `ready_o` is 1, `done_o` is 0, `bus_addr_o` and `bus_dout_o` are all zeros, and `bus_ale_o`, `bus_rd_o`, `bus_wr_o` and `bus_dout_en_o` are 0.
- R2: A request is taken at a rising edge where `req_i` and `ready_o` are both 1. The following three clock periods are bus cycles C1, C2 and C3. `bus_addr_o` carries the taken address through all three cycles.
- R3: `bus_ale_o` is 0 in the first half of C1, 1 in the second half of C1, and 0 in every other cycle.
- R4: For a read, `bus_rd_o` is 1 for the whole of C2 and C3 and 0 at all other times.
- R5: For a read, `rdata_o` takes the value of `bus_din_i` at the rising edge that ends C3. It holds that value until the next read ends, and writes leave it unchanged.
- R6: For a write, `bus_dout_en_o` is 1 and `bus_dout_o` equals the taken write data for the whole of C2 and C3.
- R7: For a write, `bus_wr_o` is 0 in the first half of C2 and 1 from mid-C2 to the end of C3. `bus_wr_o` is never 1 together with `bus_rd_o`, and never 1 without `bus_dout_en_o`.
- R8: Every transfer lasts exactly three cycles. `ready_o` is 0 in C1 to C3. `done_o` is 1 only in C3, and it is a single-cycle pulse.
- R9: `req_i` has no effect while `ready_o` is 0. If it is dropped before the transfer ends, no further transfer starts.
- R10: Changes to `addr_i`, `wdata_i` and `we_i` after a request is taken do not affect the bus for that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock; one period is one bus cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Request address |
| wdata_i | input | DATA_W | Request write data |
| ready_o | output | 1 | Idle; a request can be taken |
| done_o | output | 1 | High in the final cycle of a transfer |
| rdata_o | output | DATA_W | Data captured by the last read |
| bus_addr_o | output | ADDR_W | Address lines |
| bus_ale_o | output | 1 | Address-enable strobe |
| bus_rd_o | output | 1 | Read command |
| bus_wr_o | output | 1 | Write command |
| bus_dout_o | output | DATA_W | Write data lines |
| bus_dout_en_o | output | 1 | Write data drive enable |
| bus_din_i | input | DATA_W | Read data from memory |

## Verification
A wrong phase state shows up at the ports within one clock period. In that case `done_o` lands in the wrong cycle, or `bus_rd_o` and `bus_dout_en_o` hold for the wrong number of cycles. A falling-edge strobe register that is stuck, or that fires on the wrong edge, shows at the quarter-period samples taken in each half of C1 and C2. A fault there places `bus_ale_o` or `bus_wr_o` in the wrong half-cycle. A bad request or capture register shows as a wrong address on the bus within the same transfer. A wrong `rdata_o` appears one edge after the transfer ends, which makes a read-back after a write the check that exposes lost write timing.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_C1   = 2'd1,
    PH_C2   = 2'd2,
    PH_C3   = 2'd3
  } phase_e;
endpackage

// File: rtl/sbus_phase_ctr.sv
module sbus_phase_ctr
  import sbus_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  output phase_e phase_o
);
  phase_e phase_q, phase_d;

  always_comb begin
    case (phase_q)
      PH_IDLE: phase_d = start_i ? PH_C1 : PH_IDLE;
      PH_C1:   phase_d = PH_C2;
      PH_C2:   phase_d = PH_C3;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/sbus_mid_strobe.sv
// Half-cycle delayed strobes: armed on the falling edge, cut by the window.
module sbus_mid_strobe #(
  parameter int unsigned N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] win_i,
  output logic [N-1:0] strobe_o
);
  for (genvar g = 0; g < N; g++) begin : g_strb
    logic arm_q;
    always_ff @(negedge clk_i or negedge rst_ni) begin
      if (!rst_ni) arm_q <= 1'b0;
      else         arm_q <= win_i[g];
    end
    assign strobe_o[g] = arm_q & win_i[g];
  end
endmodule

// File: rtl/sbus_seq.sv
module sbus_seq
  import sbus_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_ale_o,
  output logic              bus_rd_o,
  output logic              bus_wr_o,
  output logic [DATA_W-1:0] bus_dout_o,
  output logic              bus_dout_en_o,
  input  logic [DATA_W-1:0] bus_din_i
);
  localparam int unsigned NSTRB = 2;
  localparam int unsigned S_ALE = 0;
  localparam int unsigned S_WR  = 1;

  phase_e            phase;
  logic              start;
  logic              busy, data_ph;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [NSTRB-1:0]  win, strb;

  assign start   = req_i & (phase == PH_IDLE);
  assign busy    = (phase != PH_IDLE);
  assign data_ph = (phase == PH_C2) | (phase == PH_C3);

  sbus_phase_ctr u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .phase_o (phase)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start) begin
      we_q    <= we_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end
  end

  // read data sampled at the edge closing C3
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         rdata_q <= '0;
    else if (phase == PH_C3 && !we_q)    rdata_q <= bus_din_i;
  end

  assign win[S_ALE] = (phase == PH_C1);
  assign win[S_WR]  = data_ph & we_q;

  sbus_mid_strobe #(.N(NSTRB)) u_strb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .win_i    (win),
    .strobe_o (strb)
  );

  assign ready_o       = ~busy;
  assign done_o        = (phase == PH_C3);
  assign rdata_o       = rdata_q;
  assign bus_addr_o    = busy ? addr_q : '0;
  assign bus_ale_o     = strb[S_ALE];
  assign bus_rd_o      = data_ph & ~we_q;
  assign bus_wr_o      = strb[S_WR];
  assign bus_dout_en_o = data_ph & we_q;
  assign bus_dout_o    = bus_dout_en_o ? wdata_q : '0;
endmodule

module sbus_seq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ready_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic              bus_ale_o,
  input logic              bus_rd_o,
  input logic              bus_wr_o,
  input logic [DATA_W-1:0] bus_dout_o,
  input logic              bus_dout_en_o
);
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!done_o && !bus_rd_o && !bus_wr_o && !bus_dout_en_o && !bus_ale_o
                 && bus_addr_o == '0 && bus_dout_o == '0));
  p_addr_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !done_o) |=> $stable(bus_addr_o));
  p_ale_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_ale_o |=> (!bus_ale_o && !ready_o && !done_o));
  p_rd_span_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_rd_o) |=> (bus_rd_o && done_o));
  p_dout_span_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bus_dout_en_o) |=> (bus_dout_en_o && done_o && $stable(bus_dout_o)));
  p_rd_wr_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_rd_o && bus_wr_o));
  p_wr_has_data_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_wr_o |-> bus_dout_en_o);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && ready_o));
  p_done_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o);
endmodule

bind sbus_seq sbus_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/sbus_mem_model.sv
module sbus_mem_model #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_ale_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic [DATA_W-1:0] bus_dout_i,
  output logic [DATA_W-1:0] bus_din_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q     <= '0;
      bus_din_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= DATA_W'(i * 16'h1357) ^ DATA_W'(16'hA5A5);
    end else begin
      if (bus_ale_i) idx_q <= bus_addr_i[IDX_W-1:0];
      bus_din_o <= bus_rd_i ? mem[idx_q] : '0;
      if (bus_wr_i) mem[idx_q] <= bus_dout_i;
    end
  end
endmodule

// File: tb/sbus_seq_tb.sv
module sbus_seq_tb;
  localparam int unsigned AW = 16;
  localparam int unsigned DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, done, ale, rd, wr, dout_en;
  logic [DW-1:0] rdata, dout, din;
  logic [AW-1:0] baddr;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] shadow [16];
  logic [DW-1:0] last_rd = '0;

  always #10 clk = ~clk;

  sbus_seq #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .done_o(done), .rdata_o(rdata),
    .bus_addr_o(baddr), .bus_ale_o(ale), .bus_rd_o(rd), .bus_wr_o(wr),
    .bus_dout_o(dout), .bus_dout_en_o(dout_en), .bus_din_i(din)
  );

  sbus_mem_model #(.ADDR_W(AW), .DATA_W(DW)) u_mem (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(baddr), .bus_ale_i(ale),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_dout_i(dout), .bus_din_o(din)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Full transfer with per-half-cycle checks; inputs scrambled after acceptance (R10)
  task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] exp_rd;
    exp_rd = shadow[a[3:0]];
    @(posedge clk); #2;
    req = 1'b1; we = w; addr = a; wdata = d;
    @(posedge clk); #2;                         // C1
    req = 1'b0; we = ~w; addr = ~a; wdata = ~d;
    #3;
    chk(!ready, "R8 ready low in C1", ready, 0);
    chk(baddr == a, "R2 addr in C1", baddr, a);
    chk(!ale, "R3 ale low first half C1", ale, 0);
    chk(!rd && !dout_en, "R4/R6 no command in C1", {rd, dout_en}, 0);
    #10;
    chk(ale, "R3 ale high second half C1", ale, 1);
    @(posedge clk); #5;                         // C2
    chk(!ale, "R3 ale low in C2", ale, 0);
    chk(baddr == a, "R10 addr held in C2", baddr, a);
    chk(rd == !w, "R4 rd in C2", rd, !w);
    chk(dout_en == w, "R6 dout_en in C2", dout_en, w);
    if (w) chk(dout == d, "R6 dout in C2", dout, d);
    chk(!wr, "R7 wr low first half C2", wr, 0);
    #10;
    chk(wr == w, "R7 wr second half C2", wr, w);
    chk(!done, "R8 no done in C2", done, 0);
    @(posedge clk); #5;                         // C3
    chk(done, "R8 done in C3", done, 1);
    chk(baddr == a, "R2 addr in C3", baddr, a);
    chk(rd == !w, "R4 rd in C3", rd, !w);
    chk(wr == w, "R7 wr in C3", wr, w);
    if (w) chk(dout == d, "R6 dout in C3", dout, d);
    @(posedge clk); #5;                         // back to idle
    chk(ready && !done, "R8 idle after 3 cycles", {ready, done}, 2'b10);
    chk(!rd && !wr && !dout_en && baddr == '0 && dout == '0, "R1 bus quiet after transfer",
        {rd, wr, dout_en}, 0);
    if (w) begin
      shadow[a[3:0]] = d;
      chk(rdata == last_rd, "R5 rdata unchanged by write", rdata, last_rd);
    end else begin
      last_rd = exp_rd;
      chk(rdata == exp_rd, "R5 read data captured", rdata, exp_rd);
    end
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic t_reset;
    #5;
    chk(ready && !done, "R1 reset ready/done", {ready, done}, 2'b10);
    chk(!ale && !rd && !wr && !dout_en, "R1 reset strobes", {ale, rd, wr, dout_en}, 0);
    chk(baddr == '0 && dout == '0 && rdata == '0, "R1 reset buses", baddr, 0);
  endtask

  // R9: request pulsed during C2 then dropped must not start a transfer
  task automatic t_busy_req;
    @(posedge clk); #2;
    req = 1'b1; we = 1'b0; addr = 16'h0003;
    @(posedge clk); #2;                         // C1
    req = 1'b0;
    @(posedge clk); #2;                         // C2
    req = 1'b1; we = 1'b1; addr = 16'h000C; wdata = 16'hDEAD;
    @(posedge clk); #2;                         // C3
    req = 1'b0;
    chk(baddr == 16'h0003, "R9 busy request ignored addr", baddr, 16'h0003);
    @(posedge clk); #5;
    chk(ready, "R9 idle after transfer", ready, 1);
    @(posedge clk); #5;
    chk(ready && baddr == '0 && !dout_en, "R9 no extra transfer", {ready, dout_en}, 2'b10);
    last_rd = shadow[3];
    chk(rdata == shadow[3], "R5 read during R9 scenario", rdata, shadow[3]);
    we = 1'b0; addr = '0; wdata = '0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) shadow[i] = DW'(i * 16'h1357) ^ DW'(16'hA5A5);
    #25 rst_n = 1'b1;
    t_reset();
    xfer(1'b0, 16'h0005, '0);
    xfer(1'b1, 16'h0005, 16'h1234);
    xfer(1'b0, 16'h0005, '0);
    xfer(1'b1, 16'hFFF0, 16'hFFFF);
    xfer(1'b1, 16'h0009, 16'h0000);
    xfer(1'b0, 16'hFFF0, '0);
    xfer(1'b0, 16'h0009, '0);
    t_busy_req();
    xfer(1'b0, 16'h000E, '0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule